// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width modulator channel. A 16-bit up-counter advances on each time-base clock enable and returns to zero after reaching the active period. The cycle is therefore one tick longer than the period value. Downstream compare logic reads the counter value, and it also reads two one-cycle event strobes. One strobe marks the counter at zero and the other marks the counter at the period.

The period register exists as two copies behind one register address. In the default buffered mode, software writes land in a holding copy. That copy moves into the active period only at the zero event, so a new frequency never takes effect in the middle of a cycle. In direct mode, the same address reaches the active period at once. A phase register supports locking several channels together. When phase loading is enabled, a synchronisation event copies the phase into the counter. The event can come from an external pulse or from a software strobe. Software can also overwrite the counter directly at any time.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter, the active period, the holding period, the phase and both control bits are 0. The register map has four addresses. Address 0 is control, with bit 0 = direct period mode and bit 1 = phase enable. Address 1 is the period, address 2 is the phase and address 3 is the counter.
- R2: With no higher-priority load, the counter increases by one on every cycle in which `tb_en` is high and keeps its value when `tb_en` is low.
- R3: On an enabled cycle where the counter is greater than or equal to the active period, the counter becomes 0, so the count sequence repeats every period+1 enabled cycles.
- R4: In buffered mode (control bit 0 = 0), a write to address 1 updates only the holding copy, and a read of address 1 returns the holding copy. The active period does not change on such a write.
- R5: In buffered mode, the holding copy is transferred to the active period on the clock edge that ends a cycle in which `cnt_zero` is high. The active period keeps its value at every other edge.
- R6: In direct mode (control bit 0 = 1), a write to address 1 updates the active period at the next edge, and a read of address 1 returns the active period.
- R7: With phase enable (control bit 1) at 0, `sync_in` and `sync_force` leave the counter unaffected.
- R8: With phase enable at 1, a high level on `sync_in` or `sync_force` loads the counter with the phase value at the next edge, whether or not `tb_en` is high.
- R9: A write to address 3 loads the counter at the next edge regardless of `tb_en`. It takes precedence over a sync load, and a sync load takes precedence over counting.
- R10: `cnt_zero` is high exactly when `tb_en` is high and the counter is 0. `cnt_prd` is high exactly when `tb_en` is high and the counter equals the active period.
- R11: `sync_out` is high for the one cycle after each cycle in which `sync_in` or `sync_force` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Time-base clock enable, one tick per high cycle |
| sync_in | input | 1 | External synchronisation pulse |
| sync_force | input | 1 | Software-forced synchronisation strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| cnt_out | output | 16 | Current counter value |
| cnt_zero | output | 1 | Counter-at-zero event strobe |
| cnt_prd | output | 1 | Counter-at-period event strobe |
| sync_out | output | 1 | Registered copy of the synchronisation event |

## Verification
The assertions take for granted that every input is a known 0 or 1 after reset is released. They also take for granted that `reg_wr` is never high with an undefined address, because each rule is keyed on the decoded write and sync conditions. The stimulus drives all inputs on the falling edge from explicit values only. It leaves every input low while the synchronised reset is still releasing. It mixes directed sequences, including simultaneous counter write, sync and enable, with a seeded random phase. In the random phase, writes are rare enough that the counter keeps running through full periods.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_PRD  = 2'd1,
    ADR_PHS  = 2'd2,
    ADR_CNT  = 2'd3
  } tb_addr_e;

  typedef struct packed {
    logic phase_en;
    logic prd_direct;
  } tb_ctrl_t;

  localparam int CTRL_W = $bits(tb_ctrl_t);

endpackage

// File: rtl/pwm_tb_rst_sync.sv
module pwm_tb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
  import pwm_tb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  tb_addr_e      addr,
  input  logic [CW-1:0] wdata,
  input  logic          zero_evt,
  input  logic [CW-1:0] cnt,
  output tb_ctrl_t      ctrl,
  output logic [CW-1:0] prd_act,
  output logic [CW-1:0] prd_shd,
  output logic [CW-1:0] phase,
  output logic [CW-1:0] rdata
);

  tb_ctrl_t      ctrl_q, ctrl_d;
  logic [CW-1:0] act_q, act_d;
  logic [CW-1:0] shd_q, shd_d;
  logic [CW-1:0] phs_q, phs_d;
  logic          wr_ctrl, wr_prd, wr_phs;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_prd  = wr && (addr == ADR_PRD);
  assign wr_phs  = wr && (addr == ADR_PHS);

  always_comb begin
    ctrl_d = ctrl_q;
    act_d  = act_q;
    shd_d  = shd_q;
    phs_d  = phs_q;
    if (wr_ctrl) begin
      ctrl_d = tb_ctrl_t'(wdata[CTRL_W-1:0]);
    end
    if (wr_phs) begin
      phs_d = wdata;
    end
    if (ctrl_q.prd_direct) begin
      if (wr_prd) begin
        act_d = wdata;
      end
    end else begin
      if (wr_prd) begin
        shd_d = wdata;
      end
      if (zero_evt) begin
        act_d = shd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      act_q  <= '0;
      shd_q  <= '0;
      phs_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      act_q  <= act_d;
      shd_q  <= shd_d;
      phs_q  <= phs_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL: rdata = {{(CW-CTRL_W){1'b0}}, ctrl_q};
      ADR_PRD:  rdata = ctrl_q.prd_direct ? act_q : shd_q;
      ADR_PHS:  rdata = phs_q;
      ADR_CNT:  rdata = cnt;
      default:  rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign prd_act = act_q;
  assign prd_shd = shd_q;
  assign phase   = phs_q;

endmodule

// File: rtl/pwm_tb_sync.sv
module pwm_tb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sync_force,
  input  logic phase_en,
  output logic sync_ld,
  output logic sync_out
);

  logic sync_evt;
  logic so_q, so_d;

  assign sync_evt = sync_in | sync_force;
  assign sync_ld  = sync_evt & phase_en;

  always_comb begin
    so_d = sync_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
    end else begin
      so_q <= so_d;
    end
  end

  assign sync_out = so_q;

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          sync_ld,
  input  logic [CW-1:0] phase,
  input  logic [CW-1:0] prd_act,
  output logic [CW-1:0] cnt,
  output logic          zero_evt,
  output logic          prd_evt
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q >= prd_act);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (sync_ld) begin
      cnt_d = phase;
    end else if (tb_en) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt      = cnt_q;
  assign zero_evt = tb_en && (cnt_q == '0);
  assign prd_evt  = tb_en && (cnt_q == prd_act);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CW = 16,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          sync_in,
  input  logic          sync_force,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic [CW-1:0] cnt_out,
  output logic          cnt_zero,
  output logic          cnt_prd,
  output logic          sync_out
);

  logic          rst_sync_n;
  tb_addr_e      addr;
  tb_ctrl_t      ctrl;
  logic [CW-1:0] prd_act, prd_shd, phase, cnt;
  logic          zero_evt, prd_evt, sync_ld, cnt_wr;

  assign addr   = tb_addr_e'(reg_addr);
  assign cnt_wr = reg_wr && (addr == ADR_CNT);

  pwm_tb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_tb_regs #(.CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (reg_wr),
    .addr     (addr),
    .wdata    (reg_wdata),
    .zero_evt (zero_evt),
    .cnt      (cnt),
    .ctrl     (ctrl),
    .prd_act  (prd_act),
    .prd_shd  (prd_shd),
    .phase    (phase),
    .rdata    (reg_rdata)
  );

  pwm_tb_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sync_in    (sync_in),
    .sync_force (sync_force),
    .phase_en   (ctrl.phase_en),
    .sync_ld    (sync_ld),
    .sync_out   (sync_out)
  );

  pwm_tb_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tb_en     (tb_en),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata),
    .sync_ld   (sync_ld),
    .phase     (phase),
    .prd_act   (prd_act),
    .cnt       (cnt),
    .zero_evt  (zero_evt),
    .prd_evt   (prd_evt)
  );

  assign cnt_out  = cnt;
  assign cnt_zero = zero_evt;
  assign cnt_prd  = prd_evt;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          tb_en,
  input logic          sync_in,
  input logic          sync_force,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [CW-1:0] reg_wdata,
  input logic [CW-1:0] cnt_out,
  input logic          cnt_zero,
  input logic          sync_out,
  input logic [CW-1:0] prd_act,
  input logic [CW-1:0] prd_shd,
  input logic [CW-1:0] phase,
  input logic          prd_direct,
  input logic          phase_en
);

  logic cw_hit, sync_hit, free_run;

  assign cw_hit   = reg_wr && (reg_addr == 2'd3);
  assign sync_hit = (sync_in || sync_force) && phase_en;
  assign free_run = !cw_hit && !sync_hit;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (free_run && tb_en && cnt_out < prd_act) |=> cnt_out == $past(cnt_out) + 1'b1); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (free_run && !tb_en) |=> $stable(cnt_out)); // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (free_run && tb_en && cnt_out >= prd_act) |=> cnt_out == '0); // R3

  AST_SHD_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == 2'd1 && !prd_direct) |=> prd_shd == $past(reg_wdata)); // R4

  AST_PRD_XFER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_zero && !prd_direct) |=> prd_act == $past(prd_shd)); // R5

  AST_PRD_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cnt_zero && !(reg_wr && reg_addr == 2'd1 && prd_direct)) |=> $stable(prd_act)); // R5

  AST_PRD_DIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == 2'd1 && prd_direct) |=> prd_act == $past(reg_wdata)); // R6

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cw_hit && sync_hit) |=> cnt_out == $past(phase)); // R8

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cw_hit |=> cnt_out == $past(reg_wdata)); // R9

  AST_SYNC_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_in || sync_force) |=> sync_out); // R11

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sync_in || sync_force) |=> !sync_out); // R11

endmodule

bind pwm_timebase pwm_timebase_chk #(.CW(CW)) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tb_en      (tb_en),
  .sync_in    (sync_in),
  .sync_force (sync_force),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .cnt_out    (cnt_out),
  .cnt_zero   (cnt_zero),
  .sync_out   (sync_out),
  .prd_act    (prd_act),
  .prd_shd    (prd_shd),
  .phase      (phase),
  .prd_direct (ctrl.prd_direct),
  .phase_en   (ctrl.phase_en)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

  logic        clk;
  logic        rst_n;
  logic        tb_en, sync_in, sync_force, reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata, cnt_out;
  logic        cnt_zero, cnt_prd, sync_out;

  int n_chk, n_fail;
  string req;

  // reference model state
  logic [15:0] m_cnt, m_act, m_shd, m_phs;
  logic        m_dir, m_pen, m_so;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
    .sync_force(sync_force), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_out(cnt_out),
    .cnt_zero(cnt_zero), .cnt_prd(cnt_prd), .sync_out(sync_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_act = 0; m_shd = 0; m_phs = 0;
    m_dir = 0; m_pen = 0; m_so = 0;
  endtask

  // one clock cycle: drive, compare, advance model
  task automatic cyc(input logic en, input logic si, input logic sf,
                     input logic wr, input logic [1:0] a, input logic [15:0] d);
    logic [15:0] exp_rd, n_cnt, n_act, n_shd, n_phs;
    logic        n_dir, n_pen;
    @(negedge clk);
    tb_en = en; sync_in = si; sync_force = sf;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #2;
    case (a)
      2'd0: exp_rd = {14'd0, m_pen, m_dir};
      2'd1: exp_rd = m_dir ? m_act : m_shd;
      2'd2: exp_rd = m_phs;
      default: exp_rd = m_cnt;
    endcase
    check("cnt_out", cnt_out, m_cnt);
    check("cnt_zero", cnt_zero, en && m_cnt == 0);           // R10
    check("cnt_prd", cnt_prd, en && m_cnt == m_act);          // R10
    check("sync_out", sync_out, m_so);                        // R11
    check("reg_rdata", reg_rdata, exp_rd);
    n_cnt = m_cnt; n_act = m_act; n_shd = m_shd; n_phs = m_phs;
    n_dir = m_dir; n_pen = m_pen;
    if (wr && a == 2'd0) begin n_dir = d[0]; n_pen = d[1]; end
    if (wr && a == 2'd2) n_phs = d;
    if (wr && a == 2'd1) begin
      if (m_dir) n_act = d; else n_shd = d;
    end
    if (!m_dir && en && m_cnt == 0) n_act = m_shd;
    if (wr && a == 2'd3) n_cnt = d;
    else if ((si || sf) && m_pen) n_cnt = m_phs;
    else if (en) n_cnt = (m_cnt >= m_act) ? 16'd0 : m_cnt + 16'd1;
    @(posedge clk);
    m_cnt = n_cnt; m_act = n_act; m_shd = n_shd; m_phs = n_phs;
    m_dir = n_dir; m_pen = n_pen; m_so = si || sf;
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) cyc(en, 0, 0, 0, 2'd3, 16'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; tb_en = 0; sync_in = 0; sync_force = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    req = "R1";   // reset values at every address
    for (int a = 0; a < 4; a++) cyc(0, 0, 0, 0, a[1:0], 16'd0);

    req = "R4";   // buffered period write, active stays 0 until zero event
    cyc(0, 0, 0, 1, 2'd1, 16'd5);
    cyc(0, 0, 0, 0, 2'd1, 16'd0);
    check("active before zero", i_pwm_timebase.cnt_prd, 0);
    req = "R5";   // zero event transfers, then counting wraps
    cyc(1, 0, 0, 0, 2'd3, 16'd0);
    req = "R3";
    idle(14, 1);
    req = "R4";   // new holding value mid-period
    cyc(1, 0, 0, 1, 2'd1, 16'd3);
    cyc(1, 0, 0, 0, 2'd1, 16'd0);
    req = "R5";
    idle(12, 1);
    req = "R2";   // gated enable
    for (int i = 0; i < 16; i++) cyc(i[0], 0, 0, 0, 2'd3, 16'd0);

    req = "R6";   // direct mode
    cyc(1, 0, 0, 1, 2'd0, 16'd1);
    cyc(1, 0, 0, 1, 2'd1, 16'd7);
    cyc(1, 0, 0, 0, 2'd1, 16'd0);
    idle(18, 1);

    req = "R7";   // sync ignored when phase disabled
    cyc(0, 0, 0, 1, 2'd2, 16'd2);
    cyc(0, 1, 0, 0, 2'd3, 16'd0);
    cyc(0, 0, 1, 0, 2'd3, 16'd0);
    cyc(0, 0, 0, 0, 2'd3, 16'd0);

    req = "R8";   // sync loads phase
    cyc(0, 0, 0, 1, 2'd0, 16'd3);
    cyc(0, 1, 0, 0, 2'd3, 16'd0);
    cyc(1, 0, 0, 0, 2'd3, 16'd0);
    cyc(1, 0, 1, 0, 2'd3, 16'd0);
    cyc(1, 1, 1, 0, 2'd3, 16'd0);
    idle(3, 1);

    req = "R9";   // priority: counter write over sync over count
    cyc(1, 1, 0, 1, 2'd3, 16'd6);
    cyc(0, 0, 0, 1, 2'd3, 16'd100);
    cyc(0, 0, 0, 0, 2'd3, 16'd0);
    req = "R3";   // above period wraps on next enable
    cyc(1, 0, 0, 0, 2'd3, 16'd0);
    idle(4, 1);

    req = "R5";   // back to buffered, zero period corner
    cyc(1, 0, 0, 1, 2'd0, 16'd2);
    cyc(1, 0, 0, 1, 2'd1, 16'd0);
    idle(10, 1);
    cyc(1, 0, 0, 1, 2'd1, 16'd4);
    idle(12, 1);

    req = "R2";   // seeded random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if (r[7:4] == 4'hF)
        cyc(r[0], r[1], 0, 1, r[3:2], 16'($urandom_range(0, 9)));
      else
        cyc(r[2] | r[3], r[4] & r[5] & r[6], r[0] & r[1] & r[7], 0,
            r[1:0], 16'd0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule